// File: doc/BRIEF.md
# PC Card Byte-Half Access Controller

This block sits between a 16-bit PC card host bus and a memory array built from two byte-wide halves: an even half holding even addresses and an odd half holding odd addresses. It watches the host's two card enables, the address bit 0, the read and write strobes and the space select. From these it drives a separate active-low read enable and write enable for each half of common memory, plus a read and write strobe pair for the attribute space. A host can therefore move a single byte or a full word on every access.

Two write-protect inputs guard the two address spaces separately. After reset a counted lockout window of `CLK_HZ/1000*LOCK_MS` clocks keeps every strobe inactive, so that no stray write reaches either space while supplies settle. A mode pin is tracked during that window and frozen once it ends. All outputs are registered and follow the sampled host inputs one clock later. There is no wait-state output, so every access completes within the host's own cycle.

Top module: `pcc_lane_ctrl`

## Requirements
- R1: While `rst` is high, all six strobe outputs are high and `cfg_mode` is 0.
- R2: For the first `LOCK_CYCLES` rising edges after `rst` falls, every strobe output stays high whatever the host drives.
- R3: `cfg_mode` takes the value of `cfg_pin` at each edge inside the lockout window, and it holds that value unchanged afterwards.
- R4: Half selection (0 = asserted): `ce1_n`=0, `ce2_n`=1, `a0`=0 selects the even half only. `ce1_n`=0, `ce2_n`=1, `a0`=1 selects the odd half only. `ce1_n`=1, `ce2_n`=0 selects the odd half only. Both enables at 0 select both halves. Both at 1 select neither.
- R5: With `reg_n`=1, `oe_n`=0 and `we_n`=1, the read enable of each selected half goes low.
- R6: With `reg_n`=1, `we_n`=0, `oe_n`=1 and `wp_n`=1, the write enable of each selected half goes low.
- R7: With `wp_n`=0, neither common-memory write enable goes low. Common reads are unaffected.
- R8: With `reg_n`=0, no common-memory enable goes low. `attr_oe_n` goes low on a read that selects the even half.
- R9: `attr_we_n` goes low on a write with `reg_n`=0 that selects the even half, but only when `wp_attr`=0.
- R10: When `oe_n` and `we_n` are both 0 in the same cycle, no strobe output goes low.
- R11: Every output reflects the inputs sampled at the previous rising edge, so strobes return high one clock after the host deasserts them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts the lockout window |
| ce1_n | input | 1 | Host card enable for the even byte (active low) |
| ce2_n | input | 1 | Host card enable for the odd byte (active low) |
| a0 | input | 1 | Host address bit 0 |
| oe_n | input | 1 | Host read strobe (active low) |
| we_n | input | 1 | Host write strobe (active low) |
| reg_n | input | 1 | Space select: 1 = common memory, 0 = attribute space |
| wp_n | input | 1 | Common-memory write protect, active low |
| wp_attr | input | 1 | Attribute-space write protect, active high; tie low when unused |
| cfg_pin | input | 1 | Mode pin captured during the lockout window |
| oe_even_n | output | 1 | Read enable, even half of common memory |
| oe_odd_n | output | 1 | Read enable, odd half of common memory |
| we_even_n | output | 1 | Write enable, even half of common memory |
| we_odd_n | output | 1 | Write enable, odd half of common memory |
| attr_oe_n | output | 1 | Attribute-space read strobe |
| attr_we_n | output | 1 | Attribute-space write strobe |
| cfg_mode | output | 1 | Captured mode pin level |

## Verification
The bench builds the block with `CLK_HZ` = 10000 and `LOCK_MS` = 3. This shrinks the lockout window to 30 clocks, so the whole window, its last edge and the mode-pin freeze all fall inside a short run. With the window that short, thousands of unlocked cycles of random strobe, space-select and protect patterns fit in the same run. Directed accesses then pin down each half-selection case, both protect inputs, the illegal read-and-write overlap and the one-clock release of a strobe.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int NUM_HALVES = 2;
  localparam int HALF_EVEN  = 0;
  localparam int HALF_ODD   = 1;

  typedef logic [NUM_HALVES-1:0] half_sel_t;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_BAD   = 2'd3
  } acc_kind_t;
endpackage

// File: rtl/pcc_half_decode.sv
module pcc_half_decode
  import pcc_pkg::*;
(
  input  logic      ce1_n,
  input  logic      ce2_n,
  input  logic      a0,
  input  logic      oe_n,
  input  logic      we_n,
  output half_sel_t sel,
  output acc_kind_t kind
);
  always_comb begin
    sel = '0;
    sel[HALF_EVEN] = !ce1_n && (!ce2_n || !a0);
    sel[HALF_ODD]  = !ce2_n || (!ce1_n && a0);
  end

  always_comb begin
    unique case ({oe_n, we_n})
      2'b01:   kind = ACC_READ;
      2'b10:   kind = ACC_WRITE;
      2'b00:   kind = ACC_BAD;
      default: kind = ACC_IDLE;
    endcase
  end
endmodule

// File: rtl/pcc_lockout.sv
module pcc_lockout #(
  parameter int LOCK_CYCLES = 150000
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_pin,
  output logic unlocked,
  output logic cfg_q
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt;

  assign unlocked = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!unlocked) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= 1'b0;
    end else if (!unlocked) begin
      cfg_q <= cfg_pin;
    end
  end

  // R3
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> $stable(cfg_q));

  // R2
  stays_open_chk: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> unlocked);
endmodule

// File: rtl/pcc_lane_ctrl.sv
module pcc_lane_ctrl
  import pcc_pkg::*;
#(
  parameter int CLK_HZ  = 50000000,
  parameter int LOCK_MS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ce1_n,
  input  logic ce2_n,
  input  logic a0,
  input  logic oe_n,
  input  logic we_n,
  input  logic reg_n,
  input  logic wp_n,
  input  logic wp_attr,
  input  logic cfg_pin,
  output logic oe_even_n,
  output logic oe_odd_n,
  output logic we_even_n,
  output logic we_odd_n,
  output logic attr_oe_n,
  output logic attr_we_n,
  output logic cfg_mode
);
  localparam int LOCK_CYCLES = (CLK_HZ / 1000) * LOCK_MS;

  half_sel_t sel;
  acc_kind_t kind;
  logic      unlocked;
  logic      cfg_q;

  pcc_half_decode u_dec (
    .ce1_n (ce1_n),
    .ce2_n (ce2_n),
    .a0    (a0),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .sel   (sel),
    .kind  (kind)
  );

  pcc_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .cfg_pin  (cfg_pin),
    .unlocked (unlocked),
    .cfg_q    (cfg_q)
  );

  logic rd_common, wr_common, rd_attr, wr_attr;

  always_comb begin
    rd_common = unlocked && reg_n && (kind == ACC_READ);
    wr_common = unlocked && reg_n && (kind == ACC_WRITE) && wp_n;
    rd_attr   = unlocked && !reg_n && (kind == ACC_READ) && sel[HALF_EVEN];
    wr_attr   = unlocked && !reg_n && (kind == ACC_WRITE) && sel[HALF_EVEN] && !wp_attr;
  end

  half_sel_t oe_q, we_q;

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst) begin
        oe_q[g] <= 1'b1;
        we_q[g] <= 1'b1;
      end else begin
        oe_q[g] <= !(rd_common && sel[g]);
        we_q[g] <= !(wr_common && sel[g]);
      end
    end
  end

  logic attr_oe_q, attr_we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      attr_oe_q <= 1'b1;
      attr_we_q <= 1'b1;
    end else begin
      attr_oe_q <= !rd_attr;
      attr_we_q <= !wr_attr;
    end
  end

  assign oe_even_n = oe_q[HALF_EVEN];
  assign oe_odd_n  = oe_q[HALF_ODD];
  assign we_even_n = we_q[HALF_EVEN];
  assign we_odd_n  = we_q[HALF_ODD];
  assign attr_oe_n = attr_oe_q;
  assign attr_we_n = attr_we_q;
  assign cfg_mode  = cfg_q;

  // R2
  lockout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> (oe_q == 2'b11 && we_q == 2'b11 && attr_oe_q && attr_we_q));

  // R7
  common_wp_chk: assert property (@(posedge clk) disable iff (rst)
    !wp_n |=> (we_even_n && we_odd_n));

  // R9
  attr_wp_chk: assert property (@(posedge clk) disable iff (rst)
    wp_attr |=> attr_we_n);

  // R10
  illegal_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !we_n) |=> (oe_q == 2'b11 && we_q == 2'b11 && attr_oe_n && attr_we_n));

  // R8
  attr_space_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_n |=> (oe_q == 2'b11 && we_q == 2'b11));

  // R5
  no_read_write_mix_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!(oe_even_n && oe_odd_n && attr_oe_n), !(we_even_n && we_odd_n && attr_we_n)}));
endmodule

// File: tb/pcc_lane_ctrl_test.sv
module pcc_lane_ctrl_test;
  localparam int PERIOD  = 10;
  localparam int CLK_HZ  = 10000;
  localparam int LOCK_MS = 3;
  localparam int LOCK    = (CLK_HZ / 1000) * LOCK_MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce1_n = 1, ce2_n = 1, a0 = 0, oe_n = 1, we_n = 1, reg_n = 1;
  logic wp_n = 1, wp_attr = 0, cfg_pin = 0;
  logic oe_even_n, oe_odd_n, we_even_n, we_odd_n, attr_oe_n, attr_we_n, cfg_mode;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  pcc_lane_ctrl #(.CLK_HZ(CLK_HZ), .LOCK_MS(LOCK_MS)) uut (
    .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2_n(ce2_n), .a0(a0),
    .oe_n(oe_n), .we_n(we_n), .reg_n(reg_n), .wp_n(wp_n), .wp_attr(wp_attr),
    .cfg_pin(cfg_pin), .oe_even_n(oe_even_n), .oe_odd_n(oe_odd_n),
    .we_even_n(we_even_n), .we_odd_n(we_odd_n), .attr_oe_n(attr_oe_n),
    .attr_we_n(attr_we_n), .cfg_mode(cfg_mode)
  );

  // Reference model: order {oe_even, oe_odd, we_even, we_odd, attr_oe, attr_we}
  logic [5:0] exp_out = 6'h3f;
  logic       exp_cfg = 1'b0;
  int         since_rst = 0;
  logic       in_reset_m = 1'b1;

  always @(posedge clk) begin
    bit even, odd, rd, wr;
    if (rst) begin
      since_rst  = 0;
      exp_out    = 6'h3f;
      exp_cfg    = 1'b0;
      in_reset_m = 1'b1;
    end else begin
      in_reset_m = 1'b0;
      even = 0; odd = 0;
      if (!ce1_n && !ce2_n) begin even = 1; odd = 1; end
      else if (!ce1_n)      begin if (a0) odd = 1; else even = 1; end
      else if (!ce2_n)      odd = 1;
      rd = (oe_n == 0) && (we_n == 1);
      wr = (we_n == 0) && (oe_n == 1);
      exp_out = 6'h3f;
      if (since_rst >= LOCK) begin
        if (reg_n) begin
          if (rd && even) exp_out[5] = 0;
          if (rd && odd)  exp_out[4] = 0;
          if (wr && wp_n && even) exp_out[3] = 0;
          if (wr && wp_n && odd)  exp_out[2] = 0;
        end else begin
          if (rd && even) exp_out[1] = 0;
          if (wr && even && !wp_attr) exp_out[0] = 0;
        end
      end
      if (since_rst < LOCK) exp_cfg = cfg_pin;
      since_rst++;
    end
  end

  function automatic string tag_for(int bitpos);
    case (bitpos)
      5, 4:    return "R5";
      3, 2:    return "R6";
      1:       return "R8";
      default: return "R9";
    endcase
  endfunction

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    logic [5:0] act;
    act = {oe_even_n, oe_odd_n, we_even_n, we_odd_n, attr_oe_n, attr_we_n};
    for (int b = 0; b < 6; b++) begin
      string t;
      t = in_reset_m ? "R1" : (since_rst <= LOCK) ? "R2" : tag_for(b);
      checks++;
      if (act[b] !== exp_out[b]) begin
        errors++;
        $display("FAIL %s output bit %0d actual %b expected %b at %0t", t, b, act[b], exp_out[b], $time);
      end
    end
    checks++;
    if (cfg_mode !== exp_cfg) begin
      errors++;
      $display("FAIL R3 cfg_mode actual %b expected %b at %0t", cfg_mode, exp_cfg, $time);
    end
  end

  task automatic drive(input logic c1, c2, ad, o, w, r, wp, wpa);
    @(negedge clk);
    ce1_n = c1; ce2_n = c2; a0 = ad; oe_n = o; we_n = w; reg_n = r; wp_n = wp; wp_attr = wpa;
  endtask

  task automatic expect6(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    @(negedge clk);
    act = {oe_even_n, oe_odd_n, we_even_n, we_odd_n, attr_oe_n, attr_we_n};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s directed actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic rand_cycle();
    int k;
    @(negedge clk);
    ce1_n = 1'($urandom); ce2_n = 1'($urandom); a0 = 1'($urandom);
    k = $urandom_range(0, 9);
    oe_n = !(k < 4); we_n = !(k >= 4 && k < 8);
    if (k == 9) begin oe_n = 0; we_n = 0; end
    reg_n = ($urandom_range(0, 3) != 0);
    wp_n = ($urandom_range(0, 3) != 0);
    wp_attr = ($urandom_range(0, 2) == 0);
    cfg_pin = 1'($urandom);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset held with active host strobes
    for (int i = 0; i < 4; i++) rand_cycle();
    @(negedge clk); rst = 0;
    // R2, R3: lockout window with random activity and a toggling mode pin
    for (int i = 0; i < LOCK + 6; i++) rand_cycle();
    cfg_pin = 1;
    // R4, R5: half selection on reads
    drive(0, 1, 0, 0, 1, 1, 1, 0); expect6("R4", 6'b011111);
    drive(0, 1, 1, 0, 1, 1, 1, 0); expect6("R4", 6'b101111);
    drive(1, 0, 0, 0, 1, 1, 1, 0); expect6("R4", 6'b101111);
    drive(0, 0, 1, 0, 1, 1, 1, 0); expect6("R4", 6'b001111);
    drive(1, 1, 0, 0, 1, 1, 1, 0); expect6("R4", 6'b111111);
    // R6: word write, then R11 release one clock later
    drive(0, 0, 0, 1, 0, 1, 1, 0); expect6("R6", 6'b110011);
    drive(0, 0, 0, 1, 1, 1, 1, 0); expect6("R11", 6'b111111);
    // R7: protected write blocked, read still passes
    drive(0, 0, 0, 1, 0, 1, 0, 0); expect6("R7", 6'b111111);
    drive(0, 0, 0, 0, 1, 1, 0, 0); expect6("R7", 6'b001111);
    // R10: overlapping strobes
    drive(0, 0, 0, 0, 0, 1, 1, 0); expect6("R10", 6'b111111);
    drive(0, 1, 0, 0, 0, 0, 1, 0); expect6("R10", 6'b111111);
    // R8, R9: attribute space
    drive(0, 1, 0, 0, 1, 0, 1, 0); expect6("R8", 6'b111101);
    drive(0, 1, 0, 1, 0, 0, 1, 0); expect6("R9", 6'b111110);
    drive(0, 1, 0, 1, 0, 0, 1, 1); expect6("R9", 6'b111111);
    drive(0, 1, 1, 0, 1, 0, 1, 0); expect6("R8", 6'b111111);
    for (int i = 0; i < 3000; i++) rand_cycle();
    // R1, R2: second reset restarts the window
    @(negedge clk); rst = 1;
    for (int i = 0; i < 3; i++) rand_cycle();
    @(negedge clk); rst = 0;
    for (int i = 0; i < LOCK + 200; i++) rand_cycle();
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule